// File: doc/BRIEF.md
# Twin-Predicated Vector Element Sequencer

This block runs the element loop of a single vector-prefixed instruction. When `start` is pulsed it samples an effective vector length and two predicate masks, one for the source side and one for the destination side. Each side then walks its own mask on its own element index. In every cycle the next active source element is paired with the next active destination element, and the pair is issued as one element operation. The operation carries register numbers for every source operand, one destination register number and, when the record option is on, a condition-field number for the result flags. Because the two indices move apart, an element can be taken from one vector position and written to another. This acts as a gather followed by a scatter, and it works for any operation, not only moves.

A predicate comes from one of four places: none (all ones), an integer register, the bitwise inverse of that same integer register, or the eq bits of a run of condition fields, which can be inverted into an ne test. An operand marked scalar keeps its base register for every element. A vector operand adds the element index to its base register. A scalar destination stops the loop after its first operation.

The controller has three states. ST_IDLE waits for `start`. It goes to ST_SCAN when the effective length is non-zero, and to ST_FIN when it is zero. ST_SCAN issues one operation per cycle while both sides still have an active element. It goes to ST_FIN when either side runs out of active elements, or right after issuing to a scalar destination. ST_FIN raises `done` for one cycle and always returns to ST_IDLE.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, `el_valid` and `done` are both low and the sequencer waits in idle.
- R2: The effective length is min(vl, maxvl, MW), where MW is 64 by default. No issued source or destination index reaches it.
- R3: If the effective length is zero, no operation is issued and `done` is high in the cycle right after the start edge.
- R4: An element whose mask bit is zero never appears as an index on that side, so a destination element with a clear bit is never written.
- R5: The k-th operation pairs the k-th set bit of the source mask with the k-th set bit of the destination mask, each counted below the effective length. With source mask 0b01 and destination mask 0b10, source element 0 goes to destination element 1.
- R6: The loop ends when either side has no set bit left below the effective length. The number of operations is the smaller of the two counts. `done` is then high for exactly one cycle, and the block goes back to idle.
- R7: Predicate mode codes are 0 = all ones, 1 = `int_pred`, 2 = bitwise inverse of `int_pred`, and 3 = condition-field eq bits.
- R8: In mode 3, mask bit i is `cr_eq[(cr_pred_base + i) mod MW]`. Setting that side's `*_cr_inv` inverts it.
- R9: When `dst_scalar` is high, exactly one operation is issued (if any is possible), with `el_dst_reg` = `dst_base`.
- R10: Source operand j issues `src_base[j]` when `src_scalar[j]` is high. Otherwise it issues (`src_base[j]` + source index) mod 2^RW. The destination register number is formed the same way with the destination index.
- R11: When `rec_en` is set, each operation raises `el_crf_we` with `el_crf` = (`rec_base` + destination index) mod MW. When `rec_en` is clear, `el_crf_we` stays low.
- R12: Operations come in back-to-back cycles, with no gaps. The first one arrives in the cycle after the start edge.
- R13: A `start` pulse while the loop is running is ignored. The running loop keeps its sampled length, masks and bases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a loop (used only in idle) |
| vl | input | 7 | Requested vector length |
| maxvl | input | 7 | Maximum vector length |
| src_pmode | input | 2 | Source predicate mode (R7 codes) |
| src_cr_inv | input | 1 | Invert source condition-field predicate |
| dst_pmode | input | 2 | Destination predicate mode (R7 codes) |
| dst_cr_inv | input | 1 | Invert destination condition-field predicate |
| int_pred | input | 64 | Integer register used as a predicate |
| cr_eq | input | 64 | eq bit of each condition field |
| cr_pred_base | input | 6 | First condition field of the predicate |
| src_scalar | input | 2 | Per-source scalar flag |
| src_base | input | 2x7 | Per-source base register |
| dst_scalar | input | 1 | Destination scalar flag |
| dst_base | input | 7 | Destination base register |
| rec_en | input | 1 | Record result flags |
| rec_base | input | 6 | First condition field for recorded flags |
| el_valid | output | 1 | Element operation issued this cycle |
| el_src_idx | output | 7 | Source element index |
| el_dst_idx | output | 7 | Destination element index |
| el_src_reg | output | 2x7 | Source register numbers |
| el_dst_reg | output | 7 | Destination register number |
| el_crf_we | output | 1 | Write result flags this cycle |
| el_crf | output | 6 | Condition field for result flags |
| done | output | 1 | Loop finished (one-cycle pulse) |

## Verification
A wrong index register shows at once, on the next operation, as a wrong element index or register number, or as an index sitting on a cleared mask bit. A wrong mask latch or length latch shows as a wrong number of operations before `done`. A state error shows as a gap in the operation stream, an extra operation after a scalar destination, or a `done` that is late, early or held for two cycles. Each of these is visible within one cycle of the wrong state, so comparing every cycle after `start` against the pairing model finds it right away.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        PM_NONE   = 2'd0,
        PM_INT    = 2'd1,
        PM_INTINV = 2'd2,
        PM_CR     = 2'd3
    } pred_mode_t;
endpackage

// File: rtl/vseq_mask_sel.sv
module vseq_mask_sel #(
    parameter int MW  = 64,
    parameter int CFW = $clog2(MW)
) (
    input  logic [1:0]     pmode,
    input  logic           cr_inv,
    input  logic [MW-1:0]  int_val,
    input  logic [MW-1:0]  cr_eq,
    input  logic [CFW-1:0] cr_base,
    output logic [MW-1:0]  mask
);
    import vseq_pkg::*;

    logic [MW-1:0] cr_mask;

    // condition-field predicate: field index wraps modulo MW
    for (genvar i = 0; i < MW; i++) begin : g_crbit
        assign cr_mask[i] = cr_eq[cr_base + CFW'(i)] ^ cr_inv;
    end

    always_comb begin
        unique case (pred_mode_t'(pmode))
            PM_NONE:   mask = '1;
            PM_INT:    mask = int_val;
            PM_INTINV: mask = ~int_val;
            PM_CR:     mask = cr_mask;
            default:   mask = '1;
        endcase
    end
endmodule

// File: rtl/vseq_find_next.sv
module vseq_find_next #(
    parameter int MW = 64,
    parameter int IW = 7
) (
    input  logic [MW-1:0] mask,
    input  logic [IW-1:0] from,
    input  logic [IW-1:0] lim,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest set bit in [from, lim)
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = MW - 1; i >= 0; i--) begin
            if (mask[i] && (IW'(i) >= from) && (IW'(i) < lim)) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
    parameter int VLW  = 7,
    parameter int MW   = 64,
    parameter int NSRC = 2,
    parameter int RW   = 7,
    localparam int CFW = $clog2(MW)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [VLW-1:0]           vl,
    input  logic [VLW-1:0]           maxvl,
    input  logic [1:0]               src_pmode,
    input  logic                     src_cr_inv,
    input  logic [1:0]               dst_pmode,
    input  logic                     dst_cr_inv,
    input  logic [MW-1:0]            int_pred,
    input  logic [MW-1:0]            cr_eq,
    input  logic [CFW-1:0]           cr_pred_base,
    input  logic [NSRC-1:0]          src_scalar,
    input  logic [NSRC-1:0][RW-1:0]  src_base,
    input  logic                     dst_scalar,
    input  logic [RW-1:0]            dst_base,
    input  logic                     rec_en,
    input  logic [CFW-1:0]           rec_base,
    output logic                     el_valid,
    output logic [VLW-1:0]           el_src_idx,
    output logic [VLW-1:0]           el_dst_idx,
    output logic [NSRC-1:0][RW-1:0]  el_src_reg,
    output logic [RW-1:0]            el_dst_reg,
    output logic                     el_crf_we,
    output logic [CFW-1:0]           el_crf,
    output logic                     done
);
    import vseq_pkg::*;

    seq_state_t state_q, state_d;

    logic [MW-1:0]           smask_c, dmask_c, smask_q, dmask_q;
    logic [VLW-1:0]          vl_min, evl_c, evl_q;
    logic [VLW-1:0]          sidx_q, didx_q, sfi, dfi;
    logic                    sf, df, pair_ok;
    logic                    dsc_q, rec_q;
    logic [NSRC-1:0]         ssc_q;
    logic [NSRC-1:0][RW-1:0] sbase_q;
    logic [RW-1:0]           dbase_q;
    logic [CFW-1:0]          rbase_q;

    vseq_mask_sel #(.MW(MW)) u_smask (
        .pmode(src_pmode), .cr_inv(src_cr_inv), .int_val(int_pred),
        .cr_eq(cr_eq), .cr_base(cr_pred_base), .mask(smask_c)
    );
    vseq_mask_sel #(.MW(MW)) u_dmask (
        .pmode(dst_pmode), .cr_inv(dst_cr_inv), .int_val(int_pred),
        .cr_eq(cr_eq), .cr_base(cr_pred_base), .mask(dmask_c)
    );

    vseq_find_next #(.MW(MW), .IW(VLW)) u_sfind (
        .mask(smask_q), .from(sidx_q), .lim(evl_q), .found(sf), .idx(sfi)
    );
    vseq_find_next #(.MW(MW), .IW(VLW)) u_dfind (
        .mask(dmask_q), .from(didx_q), .lim(evl_q), .found(df), .idx(dfi)
    );

    // effective length: min(vl, maxvl, MW)
    always_comb begin
        vl_min = (vl < maxvl) ? vl : maxvl;
        evl_c  = (vl_min > VLW'(MW)) ? VLW'(MW) : vl_min;
    end

    assign pair_ok = (state_q == ST_SCAN) && sf && df;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = (evl_c == '0) ? ST_FIN : ST_SCAN;
            ST_SCAN: if (!(sf && df) || dsc_q) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // loop context and element indices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smask_q <= '0;  dmask_q <= '0;  evl_q <= '0;
            sidx_q  <= '0;  didx_q  <= '0;
            dsc_q   <= 1'b0; rec_q  <= 1'b0; ssc_q <= '0;
            sbase_q <= '0;  dbase_q <= '0;  rbase_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            smask_q <= smask_c;  dmask_q <= dmask_c;  evl_q <= evl_c;
            sidx_q  <= '0;       didx_q  <= '0;
            dsc_q   <= dst_scalar; rec_q <= rec_en;   ssc_q <= src_scalar;
            sbase_q <= src_base; dbase_q <= dst_base; rbase_q <= rec_base;
        end else if (pair_ok) begin
            sidx_q <= sfi + 1'b1;
            didx_q <= dfi + 1'b1;
        end
    end

    // outputs
    always_comb begin
        el_valid   = pair_ok;
        el_src_idx = sfi;
        el_dst_idx = dfi;
        for (int j = 0; j < NSRC; j++) begin
            el_src_reg[j] = ssc_q[j] ? sbase_q[j] : RW'(sbase_q[j] + RW'(sfi));
        end
        el_dst_reg = dsc_q ? dbase_q : RW'(dbase_q + RW'(dfi));
        el_crf_we  = pair_ok && rec_q;
        el_crf     = rbase_q + dfi[CFW-1:0];
        done       = (state_q == ST_FIN);
    end

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: nothing follows the first operation to a scalar destination
    a_r9_scalar_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (el_valid && dsc_q) |=> !el_valid);

    // R2: issued indices stay below the effective length
    a_r2_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |-> ((el_src_idx < evl_q) && (el_dst_idx < evl_q)));

    // R4: issued indices sit on set mask bits
    a_r4_mask_hit: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |-> (smask_q[el_src_idx[CFW-1:0]] && dmask_q[el_dst_idx[CFW-1:0]]));

    // R5: each side advances strictly upward
    a_r5_src_up: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |=> (!el_valid || (el_src_idx > $past(el_src_idx))));
    a_r5_dst_up: assert property (@(posedge clk) disable iff (!rst_n)
        el_valid |=> (!el_valid || (el_dst_idx > $past(el_dst_idx))));

    // R3: zero effective length goes straight to done
    a_r3_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && evl_c == '0) |=> (done && !el_valid));
endmodule

// File: tb/tb_vec_elem_seq.sv
module tb_vec_elem_seq;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [6:0]      vl = '0, maxvl = '0;
    logic [1:0]      src_pmode = '0, dst_pmode = '0;
    logic            src_cr_inv = 1'b0, dst_cr_inv = 1'b0;
    logic [63:0]     int_pred = '0, cr_eq = '0;
    logic [5:0]      cr_pred_base = '0, rec_base = '0;
    logic [1:0]      src_scalar = '0;
    logic [1:0][6:0] src_base = '0;
    logic            dst_scalar = 1'b0;
    logic [6:0]      dst_base = '0;
    logic            rec_en = 1'b0;
    logic            el_valid, el_crf_we, done;
    logic [6:0]      el_src_idx, el_dst_idx, el_dst_reg;
    logic [1:0][6:0] el_src_reg;
    logic [5:0]      el_crf;

    int n_chk = 0;
    int n_bad = 0;
    int exp_s[128];
    int exp_d[128];
    int exp_n;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vec_elem_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .maxvl(maxvl),
        .src_pmode(src_pmode), .src_cr_inv(src_cr_inv),
        .dst_pmode(dst_pmode), .dst_cr_inv(dst_cr_inv),
        .int_pred(int_pred), .cr_eq(cr_eq), .cr_pred_base(cr_pred_base),
        .src_scalar(src_scalar), .src_base(src_base),
        .dst_scalar(dst_scalar), .dst_base(dst_base),
        .rec_en(rec_en), .rec_base(rec_base),
        .el_valid(el_valid), .el_src_idx(el_src_idx), .el_dst_idx(el_dst_idx),
        .el_src_reg(el_src_reg), .el_dst_reg(el_dst_reg),
        .el_crf_we(el_crf_we), .el_crf(el_crf), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] bmask(input logic [1:0] m, input logic inv,
                                          input logic [63:0] iv, input logic [63:0] cr,
                                          input logic [5:0] b);
        logic [63:0] r;
        case (m)
            2'd0: r = '1;
            2'd1: r = iv;
            2'd2: r = ~iv;
            default: for (int i = 0; i < 64; i++) r[i] = cr[(int'(b) + i) % 64] ^ inv;
        endcase
        return r;
    endfunction

    task automatic build_expect();
        logic [63:0] sm, dm;
        int evl, s, d;
        sm = bmask(src_pmode, src_cr_inv, int_pred, cr_eq, cr_pred_base);
        dm = bmask(dst_pmode, dst_cr_inv, int_pred, cr_eq, cr_pred_base);
        evl = (int'(vl) < int'(maxvl)) ? int'(vl) : int'(maxvl);
        if (evl > 64) evl = 64;
        s = 0; d = 0; exp_n = 0;
        forever begin
            while (s < evl && !sm[s]) s++;
            while (d < evl && !dm[d]) d++;
            if (s >= evl || d >= evl) break;
            exp_s[exp_n] = s; exp_d[exp_n] = d; exp_n++;
            s++; d++;
            if (dst_scalar) break;
        end
    endtask

    // run one loop and compare every cycle against the model
    task automatic run_loop(input string tag, input bit poke);
        int k, cyc, e_reg;
        bit seen_done;
        logic [6:0] vl_keep;
        build_expect();
        vl_keep = vl;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        k = 0; cyc = 0; seen_done = 1'b0;
        while (cyc < 300) begin
            if (done) begin seen_done = 1'b1; break; end
            if (el_valid) begin
                chk({tag, " R12 no gap"}, cyc, k);
                if (k < exp_n) begin
                    chk({tag, " R5 src idx"}, int'(el_src_idx), exp_s[k]);
                    chk({tag, " R5 dst idx"}, int'(el_dst_idx), exp_d[k]);
                    for (int j = 0; j < 2; j++) begin
                        e_reg = src_scalar[j] ? int'(src_base[j]) : (int'(src_base[j]) + exp_s[k]) % 128;
                        chk({tag, " R10 src reg"}, int'(el_src_reg[j]), e_reg);
                    end
                    e_reg = dst_scalar ? int'(dst_base) : (int'(dst_base) + exp_d[k]) % 128;
                    chk({tag, " R10 dst reg"}, int'(el_dst_reg), e_reg);
                    chk({tag, " R11 crf we"}, int'(el_crf_we), int'(rec_en));
                    if (rec_en) chk({tag, " R11 crf"}, int'(el_crf), (int'(rec_base) + exp_d[k]) % 64);
                end
                k++;
            end
            if (poke && cyc == 1) begin start = 1'b1; vl = 7'd1; end
            else start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        vl = vl_keep;
        chk({tag, " R6 done seen"}, int'(seen_done), 1);
        chk({tag, " R6 op count"}, k, exp_n);
        @(negedge clk);
        chk({tag, " R6 done one cycle"}, int'(done), 0);
        chk({tag, " R6 idle after"}, int'(el_valid), 0);
    endtask

    task automatic defaults();
        vl = 7'd4; maxvl = 7'd8;
        src_pmode = 2'd0; dst_pmode = 2'd0; src_cr_inv = 1'b0; dst_cr_inv = 1'b0;
        int_pred = '0; cr_eq = '0; cr_pred_base = '0;
        src_scalar = '0; src_base[0] = 7'd5; src_base[1] = 7'd9;
        dst_scalar = 1'b0; dst_base = 7'd1; rec_en = 1'b0; rec_base = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 valid after reset", int'(el_valid), 0);
        chk("R1 done after reset", int'(done), 0);
    endtask

    task automatic t_plain();       defaults(); run_loop("plain R7 none", 1'b0); endtask
    task automatic t_twin();
        defaults(); vl = 7'd2; maxvl = 7'd2; int_pred = 64'b10;
        src_pmode = 2'd2; dst_pmode = 2'd1;
        run_loop("twin R5 R7", 1'b0);
        chk("twin R5 pair count", exp_n, 1);
    endtask
    task automatic t_dst_only();
        defaults(); vl = 7'd2; maxvl = 7'd2; int_pred = 64'b10; dst_pmode = 2'd1;
        run_loop("dst pred R4", 1'b0);
    endtask
    task automatic t_clamp();       defaults(); vl = 7'd10; maxvl = 7'd3; run_loop("clamp R2", 1'b0); endtask
    task automatic t_zero();        defaults(); vl = 7'd0; run_loop("zero R3", 1'b0); endtask
    task automatic t_scalar_dst();  defaults(); vl = 7'd5; dst_scalar = 1'b1; run_loop("scalar dst R9", 1'b0); endtask
    task automatic t_scalar_src();  defaults(); vl = 7'd3; src_scalar = 2'b01; run_loop("scalar src R10", 1'b0); endtask
    task automatic t_cr();
        defaults(); vl = 7'd6; cr_pred_base = 6'd62;
        cr_eq = 64'h0000_0000_0000_0005 | (64'h1 << 62) | (64'h1 << 63);
        src_pmode = 2'd3; dst_pmode = 2'd3; dst_cr_inv = 1'b1;
        run_loop("cr pred R8", 1'b0);
    endtask
    task automatic t_rec();         defaults(); vl = 7'd6; rec_en = 1'b1; rec_base = 6'd60; run_loop("record R11", 1'b0); endtask
    task automatic t_long();
        defaults(); vl = 7'd100; maxvl = 7'd127; src_base[0] = 7'd100;
        run_loop("long R2 R12 R13", 1'b1);
        chk("long R2 count is MW", exp_n, 64);
    endtask
    task automatic t_empty();       defaults(); int_pred = '0; dst_pmode = 2'd1; run_loop("empty R6", 1'b0); endtask
    task automatic t_mixed();
        defaults(); vl = 7'd8; int_pred = 64'b1011_0110; src_pmode = 2'd2; dst_pmode = 2'd1;
        run_loop("mixed R5 R6", 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_twin();
        t_dst_only();
        t_clamp();
        t_zero();
        t_scalar_dst();
        t_scalar_src();
        t_cr();
        t_rec();
        t_long();
        t_empty();
        t_mixed();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule